// File: doc/BRIEF.md
# Split-Frame Load Balancer

This block steers a renderer that shares each frame between two units along one horizontal cut. The primary unit draws rows `0` to `split_row-1` and the secondary unit draws rows `split_row` up to the frame height. During a frame the block counts how many clock cycles each unit needs to report completion. At the next frame start it moves the cut so that the slower unit gets fewer rows. The size of the move is proportional to the time difference relative to the total time, scaled by the frame height and a power-of-two gain.

When both regions are finished, the secondary's pixels are carried over to the primary, which merges them with its own rows before display. For that merge the block answers, for any row presented on `line_row`, whether the row is taken from the secondary's transferred data. A status byte gives the cut position as a fraction of the frame height, for a balance indicator.

If either unit fails to finish within a timeout, the block has no usable timing for that frame. It then returns the cut to the middle of the frame. All pins are plain control and status signals: there is no streamed data path and so no back-pressure.

Top module: `split_balance_ctrl`

## Requirements
- R1: Reset state.
  - After reset, `split_row` is 0 and `split_frac` is 0.
  - Neither unit counts as finished, so the first frame is treated as having no timing history.
- R2: First frame. At the first `frame_start` after reset, `split_row` becomes `frame_height/2` (rounded down), limited by R5.
- R3: Time measurement.
  - A unit's time is the number of rising edges after the edge that sampled `frame_start`, up to and including the edge that samples its done pulse.
  - A done pulse sampled together with `frame_start` is ignored.
  - A done pulse after the unit's first done in a frame is ignored.
- R4: Rebalance rule.
  - This rule applies when both units finished in the previous frame.
  - step = floor(floor(|t_sec - t_pri| * frame_height / (t_pri + t_sec)) / 2^GAIN_SHIFT).
  - The new split is split + step when the secondary was slower, and split - step when the primary was slower.
  - The result is then limited by R5.
- R5: Clamp.
  - The new split is raised to `min_row` if it is below `min_row`, and otherwise lowered to `max_row` if it is above `max_row`.
  - Both bounds are sampled on the `frame_start` edge.
- R6: Hold. `split_row` changes only on a rising edge at which `frame_start` is 1. Changing the bounds or the height mid-frame has no effect on it.
- R7: Timeout.
  - A unit that has not signalled done by its TIMEOUT-th edge after frame start is marked missing, and a later done in that frame is ignored.
  - At the next `frame_start`, a missing unit makes the split return to `frame_height/2`, limited by R5.
- R8: Row source. `line_from_sec` is 1 exactly when `line_row >= split_row`. It is combinational from `line_row` and follows the registered split.
- R9: Fraction status.
  - `split_frac` = floor(`split_row` * 256 / `frame_height`), saturated at 255.
  - It is 0 when `frame_height` is 0.
  - It is combinational from the current `split_row` and `frame_height`.
- R10: Balanced frame. Equal times for both units leave the split unchanged, apart from the R5 limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| pri_done | input | 1 | Primary unit finished its region |
| sec_done | input | 1 | Secondary unit finished its region |
| frame_height | input | ROW_W | Rows per frame |
| min_row | input | ROW_W | Lowest allowed split row |
| max_row | input | ROW_W | Highest allowed split row |
| line_row | input | ROW_W | Row queried for its source |
| split_row | output | ROW_W | First row drawn by the secondary |
| split_frac | output | 8 | Split as a fraction of height, 1/256 units |
| line_from_sec | output | 1 | 1: row comes from secondary data |

## Verification
The bench drives frames with the secondary slower, the primary slower, equal times, and the extreme 1-versus-199 case. A design with a swapped sign would move the cut toward the slower unit. A design with a missing clamp would drive the split past `max_row` or below `min_row` through signed underflow.

A frame where the secondary never reports checks the timeout. A design that kept the previous timing would keep the old split instead of returning to the middle. Stray done pulses, both in the same cycle as `frame_start` and after the first done, check that a design measuring the wrong pulse shows a different split in the following frame.

Changing the bounds and the height in the middle of a frame checks that the cut does not move before the next boundary. A zero height checks that the fraction output shows no garbage from a division by zero.

// File: rtl/split_bal_pkg.sv
package split_bal_pkg;
  localparam int FRAC_W = 8;

  typedef enum logic {
    UNIT_PRI = 1'b0,
    UNIT_SEC = 1'b1
  } unit_e;
endpackage

// File: rtl/unit_timer.sv
module unit_timer #(
  parameter int TIMEOUT = 1024,
  parameter int CNT_W   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             done,
  output logic             running,
  output logic             finished,
  output logic [CNT_W-1:0] elapsed
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

  logic [CNT_W-1:0] cnt_inc;
  assign cnt_inc = elapsed + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      finished <= 1'b0;
      elapsed  <= '0;
    end else if (start) begin
      running  <= 1'b1;
      finished <= 1'b0;
      elapsed  <= '0;
    end else if (running) begin
      elapsed <= cnt_inc;
      if (done) begin
        running  <= 1'b0;
        finished <= 1'b1;
      end else if (cnt_inc == LIMIT) begin
        running <= 1'b0;
      end
    end
  end

  // R3: a frame start arms the counter from zero
  a_r3_arm: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && elapsed == '0 && !finished));

  // R3: the first done stops the count and marks the unit finished
  a_r3_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (running && done && !start) |=> (!running && finished));

  // R7: the count never passes the timeout limit
  a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
    elapsed <= LIMIT);

  // R7: reaching the limit without done leaves the unit unfinished
  a_r7_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !done && !start && cnt_inc == LIMIT) |=> (!running && !finished));
endmodule

// File: rtl/split_calc.sv
module split_calc #(
  parameter int ROW_W      = 11,
  parameter int CNT_W      = 11,
  parameter int GAIN_SHIFT = 1
) (
  input  logic [ROW_W-1:0] cur_split,
  input  logic [ROW_W-1:0] height,
  input  logic [ROW_W-1:0] min_row,
  input  logic [ROW_W-1:0] max_row,
  input  logic [CNT_W-1:0] t_pri,
  input  logic [CNT_W-1:0] t_sec,
  input  logic             have_hist,
  output logic [ROW_W-1:0] nxt_split
);
  localparam int SUM_W  = CNT_W + 1;
  localparam int PROD_W = CNT_W + ROW_W + 1;
  localparam int ACC_W  = ROW_W + 2;

  logic                     sec_slower;
  logic [CNT_W-1:0]         diff_mag;
  logic [SUM_W-1:0]         t_sum;
  logic [PROD_W-1:0]        prod;
  logic [PROD_W-1:0]        quot;
  logic [ROW_W-1:0]         step;
  logic signed [ACC_W-1:0]  base;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  lo;
  logic signed [ACC_W-1:0]  hi;

  always_comb begin
    sec_slower = t_sec > t_pri;
    diff_mag   = sec_slower ? (t_sec - t_pri) : (t_pri - t_sec);
    t_sum      = {1'b0, t_pri} + {1'b0, t_sec};
    prod       = PROD_W'(diff_mag) * PROD_W'(height);
    quot       = (t_sum == '0) ? '0 : (prod / PROD_W'(t_sum));
    step       = ROW_W'(quot >> GAIN_SHIFT);
    base       = signed'({2'b00, cur_split});
    lo         = signed'({2'b00, min_row});
    hi         = signed'({2'b00, max_row});
    if (!have_hist)
      acc = signed'({2'b00, height >> 1});
    else if (sec_slower)
      acc = base + signed'({2'b00, step});
    else
      acc = base - signed'({2'b00, step});
    if (acc < lo)
      nxt_split = min_row;
    else if (acc > hi)
      nxt_split = max_row;
    else
      nxt_split = ROW_W'(acc);
  end
endmodule

// File: rtl/frac_calc.sv
module frac_calc
  import split_bal_pkg::*;
#(
  parameter int ROW_W = 11
) (
  input  logic [ROW_W-1:0]  split,
  input  logic [ROW_W-1:0]  height,
  output logic [FRAC_W-1:0] frac
);
  localparam int NUM_W = ROW_W + FRAC_W;

  logic [NUM_W-1:0] num;
  logic [NUM_W-1:0] q;

  always_comb begin
    num = {split, {FRAC_W{1'b0}}};
    q   = (height == '0) ? '0 : (num / NUM_W'(height));
    if (q >= NUM_W'(1 << FRAC_W))
      frac = '1;
    else
      frac = FRAC_W'(q);
  end
endmodule

// File: rtl/split_balance_ctrl.sv
module split_balance_ctrl
  import split_bal_pkg::*;
#(
  parameter int ROW_W      = 11,
  parameter int TIMEOUT    = 1 << 20,
  parameter int GAIN_SHIFT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              pri_done,
  input  logic              sec_done,
  input  logic [ROW_W-1:0]  frame_height,
  input  logic [ROW_W-1:0]  min_row,
  input  logic [ROW_W-1:0]  max_row,
  input  logic [ROW_W-1:0]  line_row,
  output logic [ROW_W-1:0]  split_row,
  output logic [FRAC_W-1:0] split_frac,
  output logic              line_from_sec
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  logic [1:0]       done_vec;
  logic [1:0]       run_vec;
  logic [1:0]       fin_vec;
  logic [CNT_W-1:0] t_vec [2];
  logic [ROW_W-1:0] nxt_split;
  logic             have_hist;

  assign done_vec[UNIT_PRI] = pri_done;
  assign done_vec[UNIT_SEC] = sec_done;

  for (genvar g = 0; g < 2; g++) begin : g_unit
    unit_timer #(
      .TIMEOUT (TIMEOUT),
      .CNT_W   (CNT_W)
    ) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (frame_start),
      .done     (done_vec[g]),
      .running  (run_vec[g]),
      .finished (fin_vec[g]),
      .elapsed  (t_vec[g])
    );
  end

  assign have_hist = fin_vec[UNIT_PRI] & fin_vec[UNIT_SEC];

  split_calc #(
    .ROW_W      (ROW_W),
    .CNT_W      (CNT_W),
    .GAIN_SHIFT (GAIN_SHIFT)
  ) calc_i (
    .cur_split (split_row),
    .height    (frame_height),
    .min_row   (min_row),
    .max_row   (max_row),
    .t_pri     (t_vec[UNIT_PRI]),
    .t_sec     (t_vec[UNIT_SEC]),
    .have_hist (have_hist),
    .nxt_split (nxt_split)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      split_row <= '0;
    else if (frame_start)
      split_row <= nxt_split;
  end

  frac_calc #(
    .ROW_W (ROW_W)
  ) frac_i (
    .split  (split_row),
    .height (frame_height),
    .frac   (split_frac)
  );

  assign line_from_sec = (line_row >= split_row);

  // R6: the split holds between frame boundaries
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(split_row));

  // R5: a new split lies within the bounds sampled at the boundary
  a_r5_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && min_row <= max_row) |=>
      (split_row >= $past(min_row) && split_row <= $past(max_row)));

  // R7: without both timings the split recenters
  a_r7_recenter: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !have_hist && min_row <= (frame_height >> 1) &&
     (frame_height >> 1) <= max_row) |=> (split_row == ($past(frame_height) >> 1)));

  // R10: equal timings with an in-range split leave it unchanged
  a_r10_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && have_hist && t_vec[UNIT_PRI] == t_vec[UNIT_SEC] &&
     split_row >= min_row && split_row <= max_row) |=> $stable(split_row));
endmodule

// File: tb/split_balance_ctrl_tb_top.sv
module split_balance_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W      = 11;
  localparam int TMO        = 300;
  localparam int GSH        = 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             frame_start = 1'b0;
  logic             pri_done = 1'b0;
  logic             sec_done = 1'b0;
  logic [ROW_W-1:0] frame_height = 11'd480;
  logic [ROW_W-1:0] min_row = 11'd32;
  logic [ROW_W-1:0] max_row = 11'd448;
  logic [ROW_W-1:0] line_row = '0;
  logic [ROW_W-1:0] split_row;
  logic [7:0]       split_frac;
  logic             line_from_sec;

  split_balance_ctrl #(
    .ROW_W      (ROW_W),
    .TIMEOUT    (TMO),
    .GAIN_SHIFT (GSH)
  ) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .pri_done      (pri_done),
    .sec_done      (sec_done),
    .frame_height  (frame_height),
    .min_row       (min_row),
    .max_row       (max_row),
    .line_row      (line_row),
    .split_row     (split_row),
    .split_frac    (split_frac),
    .line_from_sec (line_from_sec)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    cmp_on = 1'b0;
  string cur_req = "R6";

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_split;
  int m_cnt [2];
  int m_run [2];
  int m_fin [2];
  int m_nxt, m_diff, m_sum, m_step;
  int m_done [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_split = 0;
      for (int u = 0; u < 2; u++) begin
        m_cnt[u] = 0; m_run[u] = 0; m_fin[u] = 0;
      end
    end else begin
      m_done[0] = pri_done;
      m_done[1] = sec_done;
      if (frame_start) begin
        if (m_fin[0] == 1 && m_fin[1] == 1) begin
          m_diff = m_cnt[1] - m_cnt[0];
          m_sum  = m_cnt[0] + m_cnt[1];
          m_step = (((m_diff < 0) ? -m_diff : m_diff) * int'(frame_height)) / m_sum;
          m_step = m_step / (1 << GSH);
          m_nxt  = (m_diff > 0) ? m_split + m_step : m_split - m_step;
        end else begin
          m_nxt = int'(frame_height) / 2;
        end
        if (m_nxt < int'(min_row)) m_nxt = int'(min_row);
        else if (m_nxt > int'(max_row)) m_nxt = int'(max_row);
        m_split = m_nxt;
        for (int u = 0; u < 2; u++) begin
          m_cnt[u] = 0; m_run[u] = 1; m_fin[u] = 0;
        end
      end else begin
        for (int u = 0; u < 2; u++) begin
          if (m_run[u] == 1) begin
            m_cnt[u] = m_cnt[u] + 1;
            if (m_done[u] == 1) begin
              m_run[u] = 0; m_fin[u] = 1;
            end else if (m_cnt[u] == TMO) begin
              m_run[u] = 0;
            end
          end
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    int ef;
    cycles++;
    if (cmp_on) begin
      chk(cur_req, int'(split_row), m_split, "split_row");
      if (frame_height == 0) ef = 0;
      else begin
        ef = (m_split * 256) / int'(frame_height);
        if (ef > 255) ef = 255;
      end
      chk("R9", int'(split_frac), ef, "split_frac");
      chk("R8", int'(line_from_sec), (int'(line_row) >= m_split) ? 1 : 0, "line_from_sec");
    end
    line_row = ROW_W'((cycles * 37) % 512);
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // one frame: done pulses on edge tp / ts after the start edge (0 = never)
  task automatic run_frame(input int tp, input int ts, input int len, input bit stray);
    @(negedge clk);
    frame_start = 1'b1;
    pri_done = stray; sec_done = stray;
    @(negedge clk);
    frame_start = 1'b0;
    for (int k = 1; k <= len; k++) begin
      pri_done = (k == tp) || (stray && k == tp + 3);
      sec_done = (k == ts) || (stray && k == ts + 3);
      @(negedge clk);
    end
    pri_done = 1'b0; sec_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", int'(split_row), 0, "reset split_row");
    chk("R1", int'(split_frac), 0, "reset split_frac");
    chk("R1", int'(line_from_sec), 1, "reset row source");
    cmp_on = 1'b1;

    cur_req = "R2";  run_frame(100, 300, 310, 0);
    chk("R2", int'(split_row), 240, "first frame split");
    cur_req = "R4";  run_frame(100, 300, 310, 0);
    chk("R4", int'(split_row), 360, "secondary slower grows primary");
    cur_req = "R5";  run_frame(300, 100, 310, 0);
    chk("R5", int'(split_row), 448, "clamp at max");
    cur_req = "R4";  run_frame(150, 150, 160, 0);
    chk("R4", int'(split_row), 328, "primary slower shrinks primary");
    cur_req = "R10"; run_frame(50, 50, 60, 0);
    chk("R10", int'(split_row), 328, "equal times keep split");
    cur_req = "R4";  run_frame(199, 1, 210, 0);
    run_frame(1, 199, 210, 0);
    chk("R4", int'(split_row), 91, "extreme primary-slow step");
    cur_req = "R7";  run_frame(100, 0, 320, 0);
    chk("R7", int'(split_row), 328, "split before timeout frame");
    run_frame(100, 300, 310, 0);
    chk("R7", int'(split_row), 240, "timeout recenters");
    cur_req = "R3";  run_frame(100, 300, 310, 1);
    chk("R3", int'(split_row), 360, "split before stray-pulse frame");
    cur_req = "R6";
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk("R3", int'(split_row), 448, "stray pulses ignored");
    // mid-frame bound and height changes must not move the split
    min_row = 11'd100; max_row = 11'd200; frame_height = 11'd600;
    for (int k = 1; k <= 20; k++) begin
      pri_done = (k == 10); sec_done = (k == 10);
      @(negedge clk);
    end
    pri_done = 1'b0; sec_done = 1'b0;
    chk("R6", int'(split_row), 448, "split held mid-frame");
    cur_req = "R5";  run_frame(40, 40, 50, 0);
    chk("R5", int'(split_row), 200, "new bounds applied at boundary");
    frame_height = '0;
    @(negedge clk);
    chk("R9", int'(split_frac), 0, "zero height fraction");
    frame_height = 11'd480;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule